// File: doc/BRIEF.md
# ATM Cell Ingress Port with Short-Cell Rejection

This block is the receive end of a cell-level parallel bus. An upstream cell source drives it with an active-low write strobe, a start-of-cell marker, a 16-bit data bus that can be used at 8 or 16 bits, and an odd-parity bit. The port counts bytes from each start-of-cell marker and stores them in a four-slot cell buffer. A cell becomes visible to the reader only once its final byte has arrived. If a new start-of-cell marker arrives before the current cell is complete, the partial cell is thrown away. Once a cell is complete, the port ignores any further strobes until the next marker.

The cell length is set by a two-bit code to 52, 53 or 54 bytes. In 16-bit mode the 53-byte setting is rounded up to 54, so that every cell holds a whole number of words. Each captured beat is checked for odd parity. A cell that contains a bad beat is still kept, but it sets a sticky error flag and increments an error count. A separate counter records every discarded short cell. A cell-available output tells the source whether a free slot exists; the cell currently being received counts as occupying a slot. Downstream logic reads stored cells byte by byte through a simple read port.

Top module: `cell_ingress_port`

## Requirements
- R1: After reset, `cell_avail`=1, `cells_ready`=0, `rd_valid`=0, `par_err`=0, and both counters are 0.
- R2: A beat is captured only at a rising edge where `tx_wr_n`=0. In 8-bit mode (`cfg_wide`=0) each beat stores one byte, taken from `tx_data[7:0]`; bits 15:8 are ignored.
- R3: In 16-bit mode (`cfg_wide`=1) each beat stores two bytes: `tx_data[7:0]` first, then `tx_data[15:8]`.
- R4: Length codes on `cfg_len` are 0 for 52 bytes, 1 for 53 bytes (54 in 16-bit mode), and 2 or 3 for 54 bytes. `cells_ready` rises by one after the edge that captures the final byte, and not before.
- R5: After a cell completes, beats without `tx_soc` are not stored and do not change `cells_ready`.
- R6: If `tx_soc` arrives with a captured beat while a cell is partly received, the partial bytes are discarded and `runt_cnt` rises by 1. That beat then becomes the first beat of a new cell.
- R7: A beat has good parity when the XOR of its active data bits and `tx_par` is 1. A completed cell with one or more bad beats is still stored; it sets `par_err` (sticky) and adds exactly 1 to `par_err_cnt`. A discarded short cell never counts as a parity error.
- R8: `cell_avail` = 1 exactly when (stored cells + 1 if a cell is being received) < 4. `cells_ready` never exceeds 4.
- R9: A `tx_soc` beat that arrives when all 4 slots hold stored cells and no cell is in progress is ignored. The whole cell is dropped and `runt_cnt` is unchanged.
- R10: When `rd_en`=1 and `cells_ready`>0, the next stored byte appears on `rd_data` one cycle later with `rd_valid`=1. `rd_last` marks the final byte of a cell. A read while `cells_ready`=0 is ignored.
- R11: A `tx_soc` pulse while `tx_wr_n`=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 0: 8-bit bus, 1: 16-bit bus |
| cfg_len | input | 2 | Cell length code |
| tx_wr_n | input | 1 | Active-low write strobe |
| tx_soc | input | 1 | Start-of-cell marker on the first beat |
| tx_data | input | 16 | Cell data beat |
| tx_par | input | 1 | Odd parity for the beat |
| cell_avail | output | 1 | A free cell slot exists |
| rd_en | input | 1 | Read one stored byte |
| rd_data | output | 8 | Byte read out |
| rd_valid | output | 1 | `rd_data` is valid |
| rd_last | output | 1 | Final byte of a cell |
| cells_ready | output | 3 | Number of complete stored cells |
| par_err | output | 1 | Sticky parity error flag |
| par_err_cnt | output | 8 | Number of cells that contained a bad beat |
| runt_cnt | output | 8 | Number of discarded short cells |

## Verification
The assertions assume that `cfg_wide` and `cfg_len` stay fixed while a cell is in progress. They also assume that `tx_soc` is only meaningful together with a captured beat. The stimulus changes configuration only between cells, when no cell is in progress. Every start-of-cell marker is driven on the first beat of a cell. Extra marker pulses are sent only with the strobe high, to exercise R11. Short cells are created by sending a new marker early, which is the one behaviour in which the port itself restarts mid-cell.

// File: rtl/cell_ingress_pkg.sv
package cell_ingress_pkg;
    localparam int BUS_W  = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = BUS_W / LANE_W;
    localparam int LEN_W  = 7;

    typedef enum logic [1:0] {
        LEN_52  = 2'd0,
        LEN_53  = 2'd1,
        LEN_54  = 2'd2,
        LEN_54B = 2'd3
    } cell_len_e;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic             par;
        logic             soc;
        logic             valid;
    } beat_t;

    typedef struct packed {
        logic             wr;
        logic             start;
        logic             commit;
        logic             runt;
        logic [LEN_W-1:0] off;
    } frame_ev_t;

    function automatic logic [LEN_W-1:0] eff_len(input cell_len_e code, input logic wide);
        case (code)
            LEN_52:  return LEN_W'(52);
            LEN_53:  return wide ? LEN_W'(54) : LEN_W'(53);
            default: return LEN_W'(54);
        endcase
    endfunction
endpackage

// File: rtl/cell_frame_ctl.sv
module cell_frame_ctl
    import cell_ingress_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  beat_t            beat,
    input  logic             wide,
    input  logic [LEN_W-1:0] len,
    input  logic             room,
    output frame_ev_t        ev,
    output logic             active
);
    logic [LEN_W-1:0] off_q;
    logic [LEN_W-1:0] bpb;
    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] nxt;
    logic             s_start;
    logic             s_runt;
    logic             s_wr;
    logic             s_commit;

    always_comb begin
        bpb      = wide ? LEN_W'(2) : LEN_W'(1);
        s_start  = beat.valid && beat.soc && (active || room);
        s_runt   = beat.valid && beat.soc && active;
        s_wr     = s_start || (beat.valid && !beat.soc && active);
        base     = s_start ? '0 : off_q;
        nxt      = base + bpb;
        s_commit = s_wr && (nxt >= len);
        ev.wr     = s_wr;
        ev.start  = s_start;
        ev.commit = s_commit;
        ev.runt   = s_runt;
        ev.off    = base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            off_q  <= '0;
        end else if (s_commit) begin
            active <= 1'b0;
            off_q  <= '0;
        end else if (s_wr) begin
            active <= 1'b1;
            off_q  <= nxt;
        end
    end
endmodule

// File: rtl/cell_parity_chk.sv
module cell_parity_chk
    import cell_ingress_pkg::*;
(
    input  logic [BUS_W-1:0] data,
    input  logic             par,
    input  logic             wide,
    output logic             bad
);
    logic [LANES-1:0] lane_x;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_x[i] = ^data[i*LANE_W +: LANE_W];
    end

    always_comb begin
        if (wide) bad = ~((^lane_x) ^ par);
        else      bad = ~(lane_x[0] ^ par);
    end
endmodule

// File: rtl/cell_store.sv
module cell_store
    import cell_ingress_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int SLOT_BYTES = 54
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [LEN_W-1:0]         wr_off,
    input  logic                     wide,
    input  logic [BUS_W-1:0]         wdata,
    input  logic                     commit,
    input  logic [LEN_W-1:0]         commit_len,
    input  logic                     rd_en,
    output logic [7:0]               rd_data,
    output logic                     rd_valid,
    output logic                     rd_last,
    output logic [$clog2(DEPTH):0]   used
);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int MEM_N  = DEPTH * SLOT_BYTES;
    localparam int ADDR_W = $clog2(MEM_N);

    logic [7:0]       mem_q [MEM_N];
    logic [LEN_W-1:0] len_q [DEPTH];
    logic [SLOT_W:0]  wp_q, rp_q;
    logic [LEN_W-1:0] rd_off_q;
    logic [ADDR_W-1:0] wa, ra;
    logic [LEN_W-1:0] cur_len;
    logic             rd_fire, at_end;

    always_comb begin
        wa      = ADDR_W'(wp_q[SLOT_W-1:0]) * ADDR_W'(SLOT_BYTES) + ADDR_W'(wr_off);
        ra      = ADDR_W'(rp_q[SLOT_W-1:0]) * ADDR_W'(SLOT_BYTES) + ADDR_W'(rd_off_q);
        cur_len = len_q[rp_q[SLOT_W-1:0]];
        used    = wp_q - rp_q;
        rd_fire = rd_en && (used != '0);
        at_end  = (rd_off_q == cur_len - LEN_W'(1));
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            mem_q[wa] <= wdata[7:0];
            if (wide) mem_q[wa + ADDR_W'(1)] <= wdata[15:8];
        end
        if (commit) len_q[wp_q[SLOT_W-1:0]] <= commit_len;
        rd_data <= mem_q[ra];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q     <= '0;
            rp_q     <= '0;
            rd_off_q <= '0;
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            rd_last  <= rd_fire && at_end;
            if (commit) wp_q <= wp_q + 1'b1;
            if (rd_fire) begin
                if (at_end) begin
                    rd_off_q <= '0;
                    rp_q     <= rp_q + 1'b1;
                end else begin
                    rd_off_q <= rd_off_q + LEN_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cell_ingress_port.sv
module cell_ingress_port
    import cell_ingress_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int SLOT_BYTES = 54,
    parameter int CNT_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_wide,
    input  logic [1:0]             cfg_len,
    input  logic                   tx_wr_n,
    input  logic                   tx_soc,
    input  logic [15:0]            tx_data,
    input  logic                   tx_par,
    output logic                   cell_avail,
    input  logic                   rd_en,
    output logic [7:0]             rd_data,
    output logic                   rd_valid,
    output logic                   rd_last,
    output logic [$clog2(DEPTH):0] cells_ready,
    output logic                   par_err,
    output logic [CNT_W-1:0]       par_err_cnt,
    output logic [CNT_W-1:0]       runt_cnt
);
    localparam int SLOT_W = $clog2(DEPTH);

    beat_t            beat;
    frame_ev_t        ev;
    logic             active;
    logic             beat_bad;
    logic             cell_bad_q;
    logic             cell_bad_now;
    logic [LEN_W-1:0] len;
    logic [SLOT_W+1:0] occ;

    always_comb begin
        beat.data  = tx_data;
        beat.par   = tx_par;
        beat.soc   = tx_soc;
        beat.valid = !tx_wr_n;
        len        = eff_len(cell_len_e'(cfg_len), cfg_wide);
        occ        = {1'b0, cells_ready} + {{(SLOT_W+1){1'b0}}, active};
        cell_avail = occ < (SLOT_W+2)'(DEPTH);
        cell_bad_now = (ev.start ? 1'b0 : cell_bad_q) | beat_bad;
    end

    cell_frame_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .beat   (beat),
        .wide   (cfg_wide),
        .len    (len),
        .room   (cells_ready < (SLOT_W+1)'(DEPTH)),
        .ev     (ev),
        .active (active)
    );

    cell_parity_chk u_par (
        .data (tx_data),
        .par  (tx_par),
        .wide (cfg_wide),
        .bad  (beat_bad)
    );

    cell_store #(.DEPTH(DEPTH), .SLOT_BYTES(SLOT_BYTES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr         (ev.wr),
        .wr_off     (ev.off),
        .wide       (cfg_wide),
        .wdata      (tx_data),
        .commit     (ev.commit),
        .commit_len (len),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .rd_last    (rd_last),
        .used       (cells_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_bad_q  <= 1'b0;
            par_err     <= 1'b0;
            par_err_cnt <= '0;
            runt_cnt    <= '0;
        end else begin
            if (ev.wr) cell_bad_q <= ev.commit ? 1'b0 : cell_bad_now;
            if (ev.commit && cell_bad_now) begin
                par_err     <= 1'b1;
                par_err_cnt <= par_err_cnt + CNT_W'(1);
            end
            if (ev.runt) runt_cnt <= runt_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/cell_ingress_chk.sv
module cell_ingress_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tx_wr_n,
    input logic                   cell_avail,
    input logic                   rd_en,
    input logic                   rd_valid,
    input logic                   rd_last,
    input logic [$clog2(DEPTH):0] cells_ready,
    input logic                   par_err,
    input logic [CNT_W-1:0]       par_err_cnt,
    input logic [CNT_W-1:0]       runt_cnt
);
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        cells_ready <= ($clog2(DEPTH)+1)'(DEPTH));

    p_full_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (cells_ready == ($clog2(DEPTH)+1)'(DEPTH)) |-> !cell_avail);

    p_gate_r2: assert property (@(posedge clk) disable iff (rst)
        tx_wr_n |=> (cells_ready <= $past(cells_ready)));

    p_empty_read_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cells_ready == '0) |=> !rd_valid);

    p_last_valid_r10: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid);

    p_runt_step_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(runt_cnt) |-> (runt_cnt == $past(runt_cnt) + CNT_W'(1)));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        par_err |=> par_err);

    p_err_cnt_flag_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(par_err_cnt) |-> par_err);
endmodule

bind cell_ingress_port cell_ingress_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .tx_wr_n     (tx_wr_n),
    .cell_avail  (cell_avail),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .rd_last     (rd_last),
    .cells_ready (cells_ready),
    .par_err     (par_err),
    .par_err_cnt (par_err_cnt),
    .runt_cnt    (runt_cnt)
);

// File: tb/cell_ingress_port_tb_top.sv
`timescale 1ns/1ps
module cell_ingress_port_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wide;
    logic [1:0]  cfg_len;
    logic        tx_wr_n, tx_soc, tx_par;
    logic [15:0] tx_data;
    logic        cell_avail;
    logic        rd_en;
    logic [7:0]  rd_data;
    logic        rd_valid, rd_last;
    logic [2:0]  cells_ready;
    logic        par_err;
    logic [7:0]  par_err_cnt, runt_cnt;

    logic [8:0] exp_q[$];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cell_ingress_port dut_i (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_len(cfg_len),
        .tx_wr_n(tx_wr_n), .tx_soc(tx_soc), .tx_data(tx_data), .tx_par(tx_par),
        .cell_avail(cell_avail), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_last(rd_last), .cells_ready(cells_ready),
        .par_err(par_err), .par_err_cnt(par_err_cnt), .runt_cnt(runt_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic beat(input logic [15:0] d, input bit soc, input bit bad, input bit wide);
        @(negedge clk);
        tx_wr_n = 1'b0;
        tx_soc  = soc;
        tx_data = d;
        tx_par  = wide ? ~^d : ~^d[7:0];
        if (bad) tx_par = ~tx_par;
    endtask

    task automatic idle();
        @(negedge clk);
        tx_wr_n = 1'b1;
        tx_soc  = 1'b0;
    endtask

    task automatic push_cell(input logic [7:0] base, input int len);
        for (int i = 0; i < len; i++) exp_q.push_back({(i == len-1), 8'(base + i)});
    endtask

    // sends nbytes starting at a start-of-cell; strobe-high marker gaps exercise R11
    task automatic send_cell(input int nbytes, input bit wide, input logic [7:0] base,
                             input int bad_beat, input bit keep);
        int nb;
        nb = wide ? (nbytes + 1) / 2 : nbytes;
        for (int b = 0; b < nb; b++) begin
            if (b % 7 == 3) begin
                @(negedge clk);
                tx_wr_n = 1'b1; tx_soc = 1'b1; tx_data = 16'hEEEE;
            end
            if (wide) beat({8'(base + 2*b + 1), 8'(base + 2*b)}, b == 0, b == bad_beat, 1'b1);
            else      beat({8'hA5, 8'(base + b)}, b == 0, b == bad_beat, 1'b0);
        end
        idle();
        if (keep) push_cell(base, nbytes);
    endtask

    task automatic drain(input string req);
        @(negedge clk);
        while (cells_ready != 0) begin
            rd_en = 1'b1;
            @(negedge clk);
        end
        rd_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected byte", int'(rd_data), -1);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({rd_last, rd_data} == e, "R10 readout", int'({rd_last, rd_data}), int'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wide = 1'b0; cfg_len = 2'd0;
        tx_wr_n = 1'b1; tx_soc = 1'b0; tx_data = '0; tx_par = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cell_avail == 1'b1, "R1 avail", cell_avail, 1);
        chk(cells_ready == 0, "R1 ready", cells_ready, 0);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        chk(par_err == 0 && par_err_cnt == 0, "R1 parity", par_err_cnt, 0);
        chk(runt_cnt == 0, "R1 runt", runt_cnt, 0);

        // R2 R11: 8-bit 52-byte cell
        send_cell(52, 1'b0, 8'h10, -1, 1'b1);
        chk(cells_ready == 1, "R2 commit 52", cells_ready, 1);
        // R5: strobes without marker after completion
        for (int i = 0; i < 3; i++) beat(16'h00F0, 1'b0, 1'b0, 1'b0);
        idle();
        chk(cells_ready == 1, "R5 extra beats", cells_ready, 1);
        chk(cell_avail == 1'b1, "R5 not receiving", cell_avail, 1);
        drain("R2 drain");

        // R4: 53-byte code commits exactly at the final byte
        cfg_len = 2'd1;
        send_cell(52, 1'b0, 8'h30, -1, 1'b0);
        chk(cells_ready == 0, "R4 not yet", cells_ready, 0);
        beat({8'hA5, 8'(8'h30 + 52)}, 1'b0, 1'b0, 1'b0);
        idle();
        chk(cells_ready == 1, "R4 commit 53", cells_ready, 1);
        push_cell(8'h30, 53);
        cfg_len = 2'd2;
        send_cell(54, 1'b0, 8'h60, -1, 1'b1);
        cfg_len = 2'd3;
        send_cell(54, 1'b0, 8'h80, -1, 1'b1);
        chk(cells_ready == 3, "R4 three cells", cells_ready, 3);
        drain("R4 drain");

        // R3: 16-bit mode, code 1 rounds to 54, code 0 stays 52
        cfg_wide = 1'b1; cfg_len = 2'd1;
        send_cell(54, 1'b1, 8'h40, -1, 1'b1);
        chk(cells_ready == 1, "R3 wide 54", cells_ready, 1);
        cfg_len = 2'd0;
        send_cell(52, 1'b1, 8'hC0, -1, 1'b1);
        chk(cells_ready == 2, "R3 wide 52", cells_ready, 2);
        drain("R3 drain");

        // R6: short cells discarded
        cfg_wide = 1'b0;
        send_cell(20, 1'b0, 8'h55, -1, 1'b0);
        send_cell(52, 1'b0, 8'h90, -1, 1'b1);
        chk(runt_cnt == 1, "R6 runt 8-bit", runt_cnt, 1);
        chk(cells_ready == 1, "R6 one kept", cells_ready, 1);
        cfg_wide = 1'b1;
        send_cell(10, 1'b1, 8'h22, -1, 1'b0);
        send_cell(52, 1'b1, 8'hB0, -1, 1'b1);
        chk(runt_cnt == 2, "R6 runt 16-bit", runt_cnt, 2);
        drain("R6 drain");

        // R7: parity
        chk(par_err == 1'b0, "R7 clean", par_err, 0);
        cfg_wide = 1'b0;
        send_cell(52, 1'b0, 8'h01, 5, 1'b1);
        chk(par_err == 1'b1, "R7 flag", par_err, 1);
        chk(par_err_cnt == 1, "R7 count 1", par_err_cnt, 1);
        cfg_wide = 1'b1;
        send_cell(52, 1'b1, 8'h70, 0, 1'b1);
        chk(par_err_cnt == 2, "R7 count 2", par_err_cnt, 2);
        cfg_wide = 1'b0;
        send_cell(10, 1'b0, 8'h33, 2, 1'b0);
        send_cell(52, 1'b0, 8'h44, -1, 1'b1);
        chk(par_err_cnt == 2, "R7 runt not counted", par_err_cnt, 2);
        chk(runt_cnt == 3, "R6 runt 3", runt_cnt, 3);
        drain("R7 drain");

        // R8 R9: fill the buffer
        send_cell(52, 1'b0, 8'h00, -1, 1'b1);
        send_cell(52, 1'b0, 8'h20, -1, 1'b1);
        send_cell(52, 1'b0, 8'h40, -1, 1'b1);
        chk(cell_avail == 1'b1, "R8 three stored", cell_avail, 1);
        send_cell(10, 1'b0, 8'h60, -1, 1'b0);
        chk(cell_avail == 1'b0, "R8 receiving fourth", cell_avail, 0);
        for (int i = 10; i < 52; i++) beat({8'hA5, 8'(8'h60 + i)}, 1'b0, 1'b0, 1'b0);
        idle();
        push_cell(8'h60, 52);
        chk(cells_ready == 4, "R8 full", cells_ready, 4);
        chk(cell_avail == 1'b0, "R8 full avail", cell_avail, 0);
        send_cell(52, 1'b0, 8'hD0, -1, 1'b0);
        chk(cells_ready == 4, "R9 dropped", cells_ready, 4);
        chk(runt_cnt == 3, "R9 no runt", runt_cnt, 3);
        drain("R9 drain");
        chk(cell_avail == 1'b1, "R8 empty avail", cell_avail, 1);

        // R10: read while empty
        rd_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R10 empty read", rd_valid, 0);
        rd_en = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule